// File: doc/BRIEF.md
# MDIO Management Controller

This block runs clause 22 management frames on a two-wire PHY management bus. Software sets up a small register file: a clock divider with a preamble-skip option, a target PHY and register address, and the data to send. A write to the command register then starts a single read, a single write, or a status scan. A scan re-reads one PHY register over and over and keeps a link-fail flag up to date from each result.

The block produces the management clock (MDC). It drives the data line through a separate output and output-enable, because the bidirectional pad sits outside the block. On reads it releases the line and shifts in the returned bits. Software polls the status register. The busy flag covers the whole transaction, and read data is valid once busy drops.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset every register reads zero, except the mode register, which reads the `DIV_RESET` parameter (20 by default). MDC is low and the data line is released.
- R2: While a frame runs, MDC has a period of D system clocks and is high for D/2 of them. D is bits 7:0 of the mode register with bit 0 cleared, and any value below 2 is used as 2. MDC is low whenever no frame runs.
- R3: A write frame sends 32 one bits (the preamble), then start `01`, opcode `01`, the PHY address, the register address, turnaround `10` and 16 data bits. Every field goes most significant bit first, and the data line changes only while MDC is low.
- R4: A read frame carries opcode `10`. The block releases the data line from the first turnaround bit to the end of the frame and samples the line at each MDC rising edge. It stores the 16 data bits in the receive-data register (offset 4, bits 15:0). A read that no PHY answers returns 0xFFFF through the line pull-up.
- R5: Status bit 1 (busy) is set in the cycle after a command write that starts a transaction. It stays set until the transaction has completed.
- R6: Setting bit 8 of the mode register leaves out the preamble. The frame then takes 32 MDC periods instead of 64.
- R7: Writing command bit 0 (scan) starts read frames that repeat back to back. Each one uses the programmed PHY and register address. Status bit 2 (invalid) is set when the scan starts and clears when the first scan frame completes. Status bit 0 (link fail) takes the inverse of bit 2 of each scan result.
- R8: Clearing command bit 0 during a scan lets the frame in flight finish. After that no further frame starts, busy drops and MDC stays low.
- R9: A command written while busy is set starts nothing. A transaction that is already running keeps the address and data it latched when it started.
- R10: If several command bits are written at once, write (bit 2) wins over read (bit 1), and read wins over scan (bit 0).
- R11: The register offsets are: mode 0, command 1, address 2 (PHY address in bits 4:0, register address in bits 12:8), transmit data 3 (bits 15:0), receive data 4 and status 5. Writable fields read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven out |
| mdio_oe | output | 1 | Output enable for the management data pad |
| mdio_i | input | 1 | Management data sampled from the pad |

## Verification
The assertions assume that software starts a transaction only by writing the command register. They also assume that mdio_i carries the pad value, meaning the PHY drives it only while the block has released the line, and a pull-up holds it otherwise. The bench PHY model drives the line only during the turnaround and data part of a read addressed to it, and only on MDC falling edges. The stimulus polls busy before it reprograms anything, except in the one deliberate test of commands and data written while busy.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
// Shared constants for the management controller: register offsets,
// field bit positions and frame layout.
package mdio_pkg;
    typedef enum logic [2:0] {
        RA_MODE = 3'd0,
        RA_CMD  = 3'd1,
        RA_ADDR = 3'd2,
        RA_TXD  = 3'd3,
        RA_RXD  = 3'd4,
        RA_STAT = 3'd5
    } reg_sel_e;

    localparam int CMD_SCAN    = 0;
    localparam int CMD_READ    = 1;
    localparam int CMD_WRITE   = 2;
    localparam int MODE_NOPRE  = 8;
    localparam int ST_LINKFAIL = 0;
    localparam int ST_BUSY     = 1;
    localparam int ST_INVALID  = 2;
    localparam int LINK_BIT    = 2;

    localparam int PRE_BITS    = 32;
    localparam int FRAME_BITS  = 64;
    localparam int TA_POS      = 46;
    localparam int DATA_POS    = 48;
endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
// MDC generator. While en is high it toggles mdc every div/2 system clocks
// (div rounded down to even, minimum 2). The tick outputs flag the cycle
// whose edge raises or lowers mdc. Assumes div is held stable while en is high.
module mdio_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] half;
    logic [DIV_W-1:0] cnt;
    logic             tick;

    // half period in system clocks
    always_comb half = (div < DIV_W'(2)) ? DIV_W'(1) : {1'b0, div[DIV_W-1:1]};

    assign tick      = en && (cnt == half - DIV_W'(1));
    assign rise_tick = tick && !mdc;
    assign fall_tick = tick && mdc;

    // half-period counter and clock toggle
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= !mdc;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

    assert_mdc_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !mdc);
endmodule

// File: rtl/mdio_engine.sv
`timescale 1ns/1ps
// Frame engine. On start (while idle) it latches a 64-bit frame and shifts it
// out MSB first, one bit per MDC period. The data line changes on MDC falling
// edges. On reads it releases the line from the turnaround onward and samples
// on MDC rising edges. done pulses in the cycle of the final falling edge.
module mdio_engine
    import mdio_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int DATA_W = 16,
    parameter int AD_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_write,
    input  logic              no_pre,
    input  logic [DIV_W-1:0]  div,
    input  logic [AD_W-1:0]   phy_ad,
    input  logic [AD_W-1:0]   reg_ad,
    input  logic [DATA_W-1:0] wdata,
    output logic              active,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    localparam int IDX_W = $clog2(FRAME_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] TA_IDX    = IDX_W'(TA_POS);
    localparam logic [IDX_W-1:0] DATA_IDX  = IDX_W'(DATA_POS);
    localparam logic [IDX_W-1:0] START_IDX = IDX_W'(PRE_BITS);

    logic                  is_read;
    logic [IDX_W-1:0]      idx;
    logic [FRAME_BITS-1:0] frame;
    logic [DIV_W-1:0]      div_q;
    logic [DATA_W-1:0]     shift;
    logic                  rise_tick, fall_tick;

    mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (active),
        .div       (div_q),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    assign done    = active && fall_tick && (idx == LAST_IDX);
    assign rdata   = shift;
    assign mdio_o  = frame[LAST_IDX - idx];
    assign mdio_oe = active && !(is_read && (idx >= TA_IDX));

    // frame sequencing: latch on start, sample on rise, advance on fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            is_read <= 1'b0;
            idx     <= '0;
            frame   <= '0;
            div_q   <= '0;
            shift   <= '0;
        end else if (!active) begin
            if (start) begin
                active  <= 1'b1;
                is_read <= !op_write;
                idx     <= no_pre ? START_IDX : '0;
                div_q   <= div;
                frame   <= {{PRE_BITS{1'b1}}, 2'b01, (op_write ? 2'b01 : 2'b10),
                            phy_ad, reg_ad, 2'b10, (op_write ? wdata : {DATA_W{1'b0}})};
            end
        end else begin
            if (rise_tick && is_read && (idx >= DATA_IDX))
                shift <= {shift[DATA_W-2:0], mdio_i};
            if (fall_tick) begin
                if (idx == LAST_IDX) active <= 1'b0;
                else                 idx    <= idx + IDX_W'(1);
            end
        end
    end

    assert_read_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && is_read && !mdio_oe) |=> !mdio_oe);
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
// Management controller top: the register file, command decode with
// write > read > scan priority, the busy/invalid/link-fail status and the
// scan restart. Assumes transactions start only through command writes.
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int          DIV_W     = 8,
    parameter logic [7:0]  DIV_RESET = 8'd20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int DATA_W = 16;
    localparam int AD_W   = 5;

    logic [DIV_W-1:0]  div_q;
    logic              nopre_q;
    logic [2:0]        cmd_q;
    logic [AD_W-1:0]   phy_q, rad_q;
    logic [DATA_W-1:0] txd_q, rxd_q;
    logic              linkfail_q, invalid_q;
    logic              start_req, op_wr_q, scan_on, scan_frame_q;
    logic              eng_active, eng_done;
    logic [DATA_W-1:0] eng_rdata;
    logic              busy, cmd_wr, sel_scan, scan_go;
    logic [2:0]        new_cmd;
    logic              unused_hi;

    assign unused_hi = ^reg_wdata[31:16];
    assign busy      = start_req | eng_active;
    assign cmd_wr    = reg_we && (reg_addr == RA_CMD);
    assign new_cmd   = reg_wdata[2:0];
    assign sel_scan  = !new_cmd[CMD_WRITE] && !new_cmd[CMD_READ] && new_cmd[CMD_SCAN];
    assign scan_go   = scan_on && !(cmd_wr && !new_cmd[CMD_SCAN]);

    // software-visible configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q   <= DIV_W'(DIV_RESET);
            nopre_q <= 1'b0;
            cmd_q   <= '0;
            phy_q   <= '0;
            rad_q   <= '0;
            txd_q   <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                RA_MODE: begin
                    div_q   <= reg_wdata[DIV_W-1:0];
                    nopre_q <= reg_wdata[MODE_NOPRE];
                end
                RA_CMD:  cmd_q <= new_cmd;
                RA_ADDR: begin
                    phy_q <= reg_wdata[AD_W-1:0];
                    rad_q <= reg_wdata[8+AD_W-1:8];
                end
                RA_TXD:  txd_q <= reg_wdata[DATA_W-1:0];
                default: ;
            endcase
        end
    end

    // command acceptance, scan restart and status capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_req    <= 1'b0;
            op_wr_q      <= 1'b0;
            scan_on      <= 1'b0;
            scan_frame_q <= 1'b0;
            invalid_q    <= 1'b0;
            linkfail_q   <= 1'b0;
            rxd_q        <= '0;
        end else begin
            start_req <= 1'b0;
            if (cmd_wr && !busy && (new_cmd != 3'b000)) begin
                start_req    <= 1'b1;
                op_wr_q      <= new_cmd[CMD_WRITE];
                scan_on      <= sel_scan;
                scan_frame_q <= sel_scan;
                if (sel_scan) invalid_q <= 1'b1;
            end else if (cmd_wr && !new_cmd[CMD_SCAN]) begin
                scan_on <= 1'b0;
            end
            if (eng_done) begin
                if (!op_wr_q) rxd_q <= eng_rdata;
                if (scan_frame_q) begin
                    linkfail_q <= !eng_rdata[LINK_BIT];
                    invalid_q  <= 1'b0;
                end
                if (scan_go) start_req <= 1'b1;
            end
        end
    end

    // register read mux
    always_comb begin
        case (reg_addr)
            RA_MODE: reg_rdata = {23'b0, nopre_q, div_q};
            RA_CMD:  reg_rdata = {29'b0, cmd_q};
            RA_ADDR: reg_rdata = {19'b0, rad_q, 3'b0, phy_q};
            RA_TXD:  reg_rdata = {16'b0, txd_q};
            RA_RXD:  reg_rdata = {16'b0, rxd_q};
            RA_STAT: reg_rdata = {29'b0, invalid_q, busy, linkfail_q};
            default: reg_rdata = '0;
        endcase
    end

    mdio_engine #(.DIV_W(DIV_W), .DATA_W(DATA_W), .AD_W(AD_W)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_req),
        .op_write (op_wr_q),
        .no_pre   (nopre_q),
        .div      (div_q),
        .phy_ad   (phy_q),
        .reg_ad   (rad_q),
        .wdata    (txd_q),
        .active   (eng_active),
        .done     (eng_done),
        .rdata    (eng_rdata),
        .mdc      (mdc),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .mdio_i   (mdio_i)
    );

    assert_busy_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |-> busy);
    assert_busy_until_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(eng_done));
    assert_no_start_while_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eng_active |-> !start_req);
    assert_invalid_only_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_q |-> busy);
endmodule

// File: tb/mdio_mgmt_ctrl_tb.sv
`timescale 1ns/1ps
// Bench for mdio_mgmt_ctrl: a table of transactions walked by one loop,
// then directed tests. A behavioural PHY at address 3 sits on the line.
module mdio_mgmt_ctrl_tb;
    import mdio_pkg::*;

    localparam logic [4:0] PHY_AD = 5'd3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int nchk = 0, nerr = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    mdio_mgmt_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // ---------------- PHY model with pull-up ----------------
    logic        phy_oe = 1'b0, phy_d = 1'b1, rd_match = 1'b0;
    logic        line;
    logic [15:0] pmem [32];
    logic [11:0] hdr = '0;
    logic [17:0] wbits = '0, rdvec = '0;
    int st = 0, pcnt = 0, frames = 0, rises = 0;
    int cyc = 0, last_rise = 0, prev_rise = 0, last_fall = 0;

    assign line   = mdio_oe ? mdio_o : (phy_oe ? phy_d : 1'b1);
    assign mdio_i = line;

    initial for (int i = 0; i < 32; i++) pmem[i] = 16'h0;

    always @(negedge clk) cyc++;

    always @(posedge mdc) begin
        rises++;
        prev_rise = last_rise;
        last_rise = cyc;
        case (st)
            0: if (!line) st = 1;
            1: begin if (line) begin st = 2; pcnt = 0; end else st = 0; end
            2: begin
                hdr = {hdr[10:0], line};
                pcnt++;
                if (pcnt == 12) begin
                    pcnt = 0;
                    if (hdr[11:10] == 2'b10) begin
                        st = 3;
                        rdvec = {2'b10, pmem[hdr[4:0]]};
                        rd_match = (hdr[9:5] == PHY_AD);
                    end else st = 4;
                end
            end
            3: begin pcnt++; if (pcnt == 18) begin st = 0; frames++; end end
            4: begin
                wbits = {wbits[16:0], line};
                pcnt++;
                if (pcnt == 18) begin
                    if (hdr[9:5] == PHY_AD && hdr[11:10] == 2'b01) pmem[hdr[4:0]] = wbits[15:0];
                    st = 0;
                    frames++;
                end
            end
            default: st = 0;
        endcase
    end

    always @(negedge mdc) begin
        last_fall = cyc;
        if (st == 3 && pcnt >= 1 && pcnt < 18 && rd_match) begin
            phy_oe = 1'b1;
            phy_d  = rdvec[17-pcnt];
        end else begin
            phy_oe = 1'b0;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] s;
        int n = 0;
        rd(RA_STAT, s);
        while (s[ST_BUSY] && n < 20000) begin
            @(negedge clk);
            rd(RA_STAT, s);
            n++;
        end
        chk(req, int'(s[ST_BUSY]), 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    endtask

    // fields: wr, nopre, div[7:0], phy[4:0], reg[4:0], wdata[15:0], expected read[15:0]
    localparam int NV = 7;
    localparam logic [51:0] VEC [NV] = '{
        {1'b1, 1'b0, 8'd4, 5'd3, 5'd1,  16'hA5C3, 16'h0000},
        {1'b0, 1'b0, 8'd4, 5'd3, 5'd1,  16'h0000, 16'hA5C3},
        {1'b1, 1'b1, 8'd6, 5'd3, 5'd17, 16'h3C0F, 16'h0000},
        {1'b0, 1'b1, 8'd7, 5'd3, 5'd17, 16'h0000, 16'h3C0F},
        {1'b0, 1'b0, 8'd2, 5'd9, 5'd1,  16'h0000, 16'hFFFF},
        {1'b1, 1'b0, 8'd0, 5'd3, 5'd31, 16'h8001, 16'h0000},
        {1'b0, 1'b1, 8'd1, 5'd3, 5'd31, 16'h0000, 16'h8001}
    };

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        summary();
    end

    initial begin
        logic [31:0] d;
        int f0;
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(RA_MODE, d); chk("R1 mode reset", int'(d), 20);
        rd(RA_STAT, d); chk("R1 status reset", int'(d), 0);
        rd(RA_RXD, d);  chk("R1 rxdata reset", int'(d), 0);
        chk("R1 mdc low", int'(mdc), 0);
        chk("R1 line released", int'(mdio_oe), 0);

        // R11 field readback
        wr(RA_ADDR, 32'hFFFF_FFFF); rd(RA_ADDR, d); chk("R11 address fields", int'(d), 32'h1F1F);
        wr(RA_MODE, 32'hFFFF_FFFF); rd(RA_MODE, d); chk("R11 mode fields", int'(d), 32'h1FF);
        wr(RA_TXD, 32'hFFFF_5AA5);  rd(RA_TXD, d);  chk("R11 txdata field", int'(d), 32'h5AA5);

        // table of transactions
        for (int i = 0; i < NV; i++) begin
            logic [51:0] v;
            int eff, exp_rises, r0;
            v = VEC[i];
            eff = (v[49:42] < 2) ? 2 : int'({v[49:43], 1'b0});
            exp_rises = v[50] ? 32 : 64;
            wr(RA_MODE, {23'b0, v[50], v[49:42]});
            wr(RA_ADDR, {19'b0, v[36:32], 3'b0, v[41:37]});
            wr(RA_TXD, {16'b0, v[31:16]});
            r0 = rises; f0 = frames;
            wr(RA_CMD, v[51] ? 32'h4 : 32'h2);
            rd(RA_STAT, d); chk("R5 busy after command", int'(d[ST_BUSY]), 1);
            wait_idle("R5 busy drops at end");
            chk(v[50] ? "R6 MDC periods without preamble" : "R3 MDC periods with preamble",
                rises - r0, exp_rises);
            chk("R2 MDC period", last_rise - prev_rise, eff);
            chk("R2 MDC high time", last_fall - last_rise, eff / 2);
            chk("R2 MDC low when idle", int'(mdc), 0);
            chk("R3 one frame seen by PHY", frames - f0, 1);
            if (v[51]) begin
                chk("R3 PHY received write data", int'(pmem[v[36:32]]), int'(v[31:16]));
            end else begin
                rd(RA_RXD, d); chk("R4 read data", int'(d), int'(v[15:0]));
            end
        end

        // R7 scan: invalid, link fail, repetition
        pmem[1] = 16'h7809;
        wr(RA_MODE, 32'h4);
        wr(RA_ADDR, {19'b0, 5'd1, 3'b0, PHY_AD});
        wr(RA_CMD, 32'h1);
        rd(RA_STAT, d); chk("R7 invalid at scan start", int'(d[ST_INVALID]), 1);
        begin
            int n = 0;
            rd(RA_STAT, d);
            while (d[ST_INVALID] && n < 5000) begin @(negedge clk); rd(RA_STAT, d); n++; end
        end
        rd(RA_STAT, d);
        chk("R7 invalid cleared", int'(d[ST_INVALID]), 0);
        chk("R7 link fail set", int'(d[ST_LINKFAIL]), 1);
        chk("R7 still scanning", int'(d[ST_BUSY]), 1);
        rd(RA_RXD, d); chk("R7 scan result", int'(d), 16'h7809);
        pmem[1] = 16'h780D;
        f0 = frames;
        begin
            int n = 0;
            while (frames < f0 + 2 && n < 5000) begin @(negedge clk); n++; end
        end
        rd(RA_STAT, d); chk("R7 link fail follows result", int'(d[ST_LINKFAIL]), 0);

        // R8 stop scan
        wr(RA_CMD, 32'h0);
        wait_idle("R8 busy drops after scan stop");
        f0 = frames;
        repeat (400) @(negedge clk);
        chk("R8 no frame after stop", frames - f0, 0);
        chk("R8 MDC stays low", int'(mdc), 0);

        // R9 command and data written while busy
        wr(RA_MODE, 32'h8);
        wr(RA_ADDR, {19'b0, 5'd9, 3'b0, PHY_AD});
        wr(RA_TXD, 32'h0F0F);
        f0 = frames;
        wr(RA_CMD, 32'h4);
        repeat (50) @(negedge clk);
        wr(RA_TXD, 32'hFFFF);
        wr(RA_CMD, 32'h2);
        wait_idle("R9 busy drops");
        repeat (300) @(negedge clk);
        chk("R9 single frame", frames - f0, 1);
        chk("R9 latched data kept", int'(pmem[9]), 16'h0F0F);

        // R10 priority write over read over scan
        wr(RA_MODE, 32'h2);
        wr(RA_ADDR, {19'b0, 5'd5, 3'b0, PHY_AD});
        wr(RA_TXD, 32'h1234);
        f0 = frames;
        wr(RA_CMD, 32'h7);
        wait_idle("R10 busy drops");
        repeat (300) @(negedge clk);
        chk("R10 write performed", int'(pmem[5]), 16'h1234);
        chk("R10 no scan restart", frames - f0, 1);
        rd(RA_STAT, d); chk("R10 invalid stays clear", int'(d[ST_INVALID]), 0);

        summary();
    end
endmodule